// File: doc/BRIEF.md
# Write-Only Stimulus Port Slave

This block is a memory-mapped slave that turns software instrumentation writes into stimulus records. Each accepted write produces one record on a valid/ready stream. The record holds a six-bit master field, a sixteen-bit channel number, an eight-bit offset inside the stimulus port, the write data and the byte strobes. The slave uses a simplified AXI-style protocol with single-beat transfers only. A sideband carrying the requester identity travels with the write address.

All requesters share one aligned 16 MB window. The master field is never taken from the address. It is rebuilt from the requester identity: the upper four identity bits are concatenated with a two-bit core index, which is taken from the two lowest identity bits. Address bits 23:0 pass through and are split into a channel and an offset. The top address bits play no part.

The slave cannot be read. Any read is accepted and answered with zero data and an OKAY response, and the read address is not carried into the block. Downstream packet formatting and arbitration between masters belong to other blocks.

Top module: `stim_wslave`

## Requirements
- R1: After reset, rec_valid, s_bvalid and s_rvalid are 0, and s_awready, s_wready and s_arready are 1.
- R2: rec_mid equals {s_awsrc[9:6], s_awsrc[1:0]}. Address bits 29:24 have no effect on any record field.
- R3: Address bits 31:30 have no effect on any record field.
- R4: rec_chan equals address bits 23:8 and rec_offs equals address bits 7:0 of the accepted write address.
- R5: rec_data and rec_strb equal the s_wdata and s_wstrb of the accepted write-data beat.
- R6: The write address and the write data may be accepted in either order, or in the same cycle. rec_valid goes to 1 only after both have been accepted, and at that point neither s_awready nor s_wready is 1.
- R7: While rec_valid is 1 and rec_ready is 0, rec_valid stays 1 and every record field stays unchanged.
- R8: s_bvalid rises in the cycle after the record handshake, with s_bresp = 2'b00 (OKAY). It stays 1 until s_bready is sampled high, and s_bvalid is never 1 before the record has been taken.
- R9: After a channel handshake (address or data), that channel's ready stays 0 until the write response has completed. A second address or data beat is not accepted before then.
- R10: s_arready is 1 whenever s_rvalid is 0. s_rvalid rises in the cycle after a read-address handshake with s_rdata = 0 and s_rresp = 2'b00, and it stays 1 until s_rready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 32 | Write address |
| s_awsrc | input | 10 | Requester identity sideband, sampled with the address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data, always zero |
| s_rresp | output | 2 | Read response code, always OKAY |
| rec_valid | output | 1 | Stimulus record valid |
| rec_ready | input | 1 | Stimulus record ready |
| rec_mid | output | 6 | Master field of the record |
| rec_chan | output | 16 | Channel number |
| rec_offs | output | 8 | Offset within the stimulus port |
| rec_data | output | 32 | Record data |
| rec_strb | output | 4 | Record byte strobes |

## Verification
The hardest case to reach is a half-complete write: one channel has been accepted and is held while the other channel has not yet arrived. In that state the block must show no record and must refuse a second beat on the held channel. The bench drives the two channels in a chosen order with a gap of random length between them. During the gap it checks the record and ready outputs. Back-pressure on the record stream and on the write response is then held for random lengths, so the stability and response timing are checked under stall.

// File: rtl/stim_pkg.sv
package stim_pkg;
  localparam int MID_W  = 6;
  localparam int CHAN_W = 16;
  localparam int OFFS_W = 8;
  localparam int CHAN_LO = 8;
  localparam int CHAN_HI = 23;
  localparam int OFFS_HI = 7;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  // master field: requester upper nibble followed by core index
  function automatic logic [MID_W-1:0] map_mid(input logic [3:0] hi, input logic [1:0] core);
    return {hi, core};
  endfunction

  function automatic logic [CHAN_W-1:0] addr_chan(input logic [CHAN_HI:0] a);
    return a[CHAN_HI:CHAN_LO];
  endfunction

  function automatic logic [OFFS_W-1:0] addr_offs(input logic [CHAN_HI:0] a);
    return a[OFFS_HI:0];
  endfunction
endpackage

// File: rtl/stim_aw_cap.sv
module stim_aw_cap import stim_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  src,
  input  logic              block,
  input  logic              clr,
  output logic              ready,
  output logic              full,
  output logic [MID_W-1:0]  mid_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic [OFFS_W-1:0] offs_q
);
  localparam int MID_TOP = SRC_W - 1;
  localparam int MID_BOT = SRC_W - 4;

  logic take;
  logic unused_bits;

  assign ready = ~full & ~block;
  assign take  = valid & ready;
  assign unused_bits = ^{addr[ADDR_W-1:CHAN_HI+1], src[MID_BOT-1:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      mid_q  <= '0;
      chan_q <= '0;
      offs_q <= '0;
    end else if (take) begin
      full   <= 1'b1;
      mid_q  <= map_mid(src[MID_TOP:MID_BOT], src[1:0]);
      chan_q <= addr_chan(addr[CHAN_HI:0]);
      offs_q <= addr_offs(addr[CHAN_HI:0]);
    end else if (clr) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/stim_w_cap.sv
module stim_w_cap #(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [STRB_W-1:0] strb,
  input  logic              block,
  input  logic              clr,
  output logic              ready,
  output logic              full,
  output logic [DATA_W-1:0] data_q,
  output logic [STRB_W-1:0] strb_q
);
  logic take;

  assign ready = ~full & ~block;
  assign take  = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
      strb_q <= '0;
    end else if (take) begin
      full   <= 1'b1;
      data_q <= data;
      strb_q <= strb;
    end else if (clr) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/stim_rd_resp.sv
module stim_rd_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic arvalid,
  input  logic rready,
  output logic arready,
  output logic rvalid
);
  assign arready = ~rvalid | rready;

  always_ff @(posedge clk) begin
    if (!rst_n)                 rvalid <= 1'b0;
    else if (arvalid & arready) rvalid <= 1'b1;
    else if (rready)            rvalid <= 1'b0;
  end
endmodule

// File: rtl/stim_wslave.sv
module stim_wslave import stim_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 10,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [SRC_W-1:0]  s_awsrc,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [MID_W-1:0]  rec_mid,
  output logic [CHAN_W-1:0] rec_chan,
  output logic [OFFS_W-1:0] rec_offs,
  output logic [DATA_W-1:0] rec_data,
  output logic [STRB_W-1:0] rec_strb
);
  logic aw_full, w_full;
  logic rec_fire;
  logic b_pend;

  assign rec_valid = aw_full & w_full;
  assign rec_fire  = rec_valid & rec_ready;

  stim_aw_cap #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_aw (
    .clk(clk), .rst_n(rst_n), .valid(s_awvalid), .addr(s_awaddr), .src(s_awsrc),
    .block(b_pend), .clr(rec_fire), .ready(s_awready), .full(aw_full),
    .mid_q(rec_mid), .chan_q(rec_chan), .offs_q(rec_offs)
  );

  stim_w_cap #(.DATA_W(DATA_W)) u_w (
    .clk(clk), .rst_n(rst_n), .valid(s_wvalid), .data(s_wdata), .strb(s_wstrb),
    .block(b_pend), .clr(rec_fire), .ready(s_wready), .full(w_full),
    .data_q(rec_data), .strb_q(rec_strb)
  );

  stim_rd_resp u_rd (
    .clk(clk), .rst_n(rst_n), .arvalid(s_arvalid), .rready(s_rready),
    .arready(s_arready), .rvalid(s_rvalid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        b_pend <= 1'b0;
    else if (rec_fire) b_pend <= 1'b1;
    else if (s_bready) b_pend <= 1'b0;
  end

  assign s_bvalid = b_pend;
  assign s_bresp  = RESP_OKAY;
  assign s_rdata  = '0;
  assign s_rresp  = RESP_OKAY;
endmodule

// File: rtl/stim_wslave_chk.sv
module stim_wslave_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic              rec_fire,
  input logic [5:0]        rec_mid,
  input logic [15:0]       rec_chan,
  input logic [7:0]        rec_offs,
  input logic [DATA_W-1:0] rec_data
);
  p_rec_both_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (!s_awready && !s_wready));

  p_rec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_mid) && $stable(rec_chan)
                                   && $stable(rec_offs) && $stable(rec_data)));

  p_b_after_rec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_fire |=> s_bvalid);

  p_b_okay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> (s_bresp == 2'b00));

  p_b_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);

  p_b_not_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bvalid) |-> $past(rec_fire));

  p_aw_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awvalid && s_awready) |=> !s_awready);

  p_w_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wvalid && s_wready) |=> !s_wready);

  p_r_after_ar_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_arvalid && s_arready) |=> s_rvalid);

  p_r_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> (s_rdata == '0 && s_rresp == 2'b00));

  p_r_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> s_rvalid);

  p_ar_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_rvalid |-> s_arready);
endmodule

bind stim_wslave stim_wslave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wvalid(s_wvalid), .s_wready(s_wready), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_bresp(s_bresp), .s_arvalid(s_arvalid), .s_arready(s_arready), .s_rvalid(s_rvalid),
  .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rec_fire(rec_fire), .rec_mid(rec_mid), .rec_chan(rec_chan),
  .rec_offs(rec_offs), .rec_data(rec_data)
);

// File: tb/stim_wslave_bench.sv
module stim_wslave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
  logic        s_arvalid = 1'b0, s_rready = 1'b0, rec_ready = 1'b0;
  logic [31:0] s_awaddr = '0, s_wdata = '0;
  logic [9:0]  s_awsrc = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, rec_valid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata, rec_data;
  logic [5:0]  rec_mid;
  logic [15:0] rec_chan;
  logic [7:0]  rec_offs;
  logic [3:0]  rec_strb;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stim_wslave u_stim_wslave (
    .clk(clk), .rst_n(rst_n), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_awaddr(s_awaddr), .s_awsrc(s_awsrc), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_bresp(s_bresp), .s_arvalid(s_arvalid), .s_arready(s_arready), .s_rvalid(s_rvalid),
    .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_mid(rec_mid), .rec_chan(rec_chan), .rec_offs(rec_offs),
    .rec_data(rec_data), .rec_strb(rec_strb)
  );

  function automatic logic [5:0] exp_mid(input logic [9:0] src);
    return 6'(((src >> 6) << 2) | (src & 10'h3));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // hold valids until each handshake is seen at a rising edge
  task automatic pump();
    bit a_ok, w_ok;
    do begin
      a_ok = s_awvalid & s_awready;
      w_ok = s_wvalid & s_wready;
      @(posedge clk);
      @(negedge clk);
      if (a_ok) s_awvalid = 1'b0;
      if (w_ok) s_wvalid = 1'b0;
    end while (s_awvalid | s_wvalid);
  endtask

  task automatic write_txn(input logic [31:0] a, input logic [9:0] src, input logic [31:0] d,
                           input logic [3:0] st, input int order, input int gap,
                           input int rgap, input int bgap);
    s_awaddr = a; s_awsrc = src; s_wdata = d; s_wstrb = st;
    if (order == 0) begin
      s_awvalid = 1'b1; pump();
      for (int i = 0; i < gap; i++) begin
        chk(rec_valid == 1'b0, "R6 no record before data", rec_valid, 0);
        chk(s_awready == 1'b0, "R9 address held", s_awready, 0);
        @(negedge clk);
      end
      s_wvalid = 1'b1; pump();
    end else if (order == 1) begin
      s_wvalid = 1'b1; pump();
      for (int i = 0; i < gap; i++) begin
        chk(rec_valid == 1'b0, "R6 no record before address", rec_valid, 0);
        chk(s_wready == 1'b0, "R9 data held", s_wready, 0);
        @(negedge clk);
      end
      s_awvalid = 1'b1; pump();
    end else begin
      s_awvalid = 1'b1; s_wvalid = 1'b1; pump();
    end
    s_awaddr = $urandom; s_awsrc = 10'($urandom); s_wdata = $urandom; s_wstrb = 4'($urandom);
    chk(rec_valid == 1'b1, "R6 record after both", rec_valid, 1);
    chk(s_awready == 1'b0 && s_wready == 1'b0, "R6 both channels closed", {s_awready, s_wready}, 0);
    for (int i = 0; i <= rgap; i++) begin
      chk(rec_mid == exp_mid(src), "R2 master field", rec_mid, exp_mid(src));
      chk(rec_chan == a[23:8], "R4 channel", rec_chan, a[23:8]);
      chk(rec_offs == a[7:0], "R4 offset", rec_offs, a[7:0]);
      chk(rec_data == d && rec_strb == st, "R5 data and strobes", {rec_data, rec_strb}, {d, st});
      chk(s_bvalid == 1'b0, "R8 no response before record taken", s_bvalid, 0);
      if (i > 0) chk(rec_valid == 1'b1, "R7 record held", rec_valid, 1);
      if (i < rgap) @(negedge clk);
    end
    rec_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rec_ready = 1'b0;
    chk(s_bvalid == 1'b1 && s_bresp == 2'b00, "R8 response after record", {s_bvalid, s_bresp}, 3'b100);
    chk(rec_valid == 1'b0, "R8 record consumed", rec_valid, 0);
    for (int i = 0; i < bgap; i++) begin
      @(negedge clk);
      chk(s_bvalid == 1'b1, "R8 response held", s_bvalid, 1);
      chk(s_awready == 1'b0 && s_wready == 1'b0, "R9 closed until response", {s_awready, s_wready}, 0);
    end
    s_bready = 1'b1;
    @(posedge clk); @(negedge clk);
    s_bready = 1'b0;
    chk(s_bvalid == 1'b0, "R8 response retired", s_bvalid, 0);
    chk(s_awready == 1'b1 && s_wready == 1'b1, "R9 reopened", {s_awready, s_wready}, 2'b11);
  endtask

  task automatic read_txn(input int hold);
    s_arvalid = 1'b1;
    chk(s_arready == 1'b1, "R10 read address ready", s_arready, 1);
    @(posedge clk); @(negedge clk);
    s_arvalid = 1'b0;
    chk(s_rvalid == 1'b1, "R10 read data next cycle", s_rvalid, 1);
    chk(s_rdata == 0 && s_rresp == 2'b00, "R10 zero OKAY", {s_rdata, s_rresp}, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(s_rvalid == 1'b1, "R10 read data held", s_rvalid, 1);
    end
    s_rready = 1'b1;
    @(posedge clk); @(negedge clk);
    s_rready = 1'b0;
    chk(s_rvalid == 1'b0, "R10 read retired", s_rvalid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rec_valid == 0 && s_bvalid == 0 && s_rvalid == 0, "R1 valids low",
        {rec_valid, s_bvalid, s_rvalid}, 0);
    chk(s_awready && s_wready && s_arready, "R1 readies high",
        {s_awready, s_wready, s_arready}, 3'b111);

    // R3 / R2 directed: top address bits all ones must not leak
    write_txn(32'hFFAB_CD12, 10'h3C1, 32'hDEAD_BEEF, 4'hF, 0, 2, 1, 1);
    write_txn(32'hC000_0000, 10'h000, 32'h0, 4'h0, 1, 3, 0, 0);
    write_txn(32'h3F00_00FF, 10'h3FF, 32'h1234_5678, 4'h5, 2, 0, 3, 2);
    // R3: identical low bits and source, different bits 31:24, same record
    write_txn(32'h8012_3456, 10'h2A5, 32'hA5A5_5A5A, 4'h9, 2, 0, 0, 0);
    write_txn(32'h4112_3456, 10'h2A5, 32'hA5A5_5A5A, 4'h9, 0, 1, 0, 0);

    read_txn(0);
    read_txn(3);

    for (int k = 0; k < 60; k++) begin
      write_txn($urandom, 10'($urandom), $urandom, 4'($urandom), int'($urandom % 3),
                int'($urandom % 4), int'($urandom % 4), int'($urandom % 3));
      if ($urandom % 4 == 0) read_txn(int'($urandom % 3));
    end
    finish_run();
  end
endmodule